// File: doc/BRIEF.md
# Tapped Binary Divider With Oscillator Gating

This block divides a free-running oscillator clock by powers of two. It holds a chain of binary stages. Each stage runs at half the rate of the stage below it, so stage n toggles at the input rate divided by 2^n. The chain advances once per falling edge of the oscillator clock. A chosen subset of the stages is exposed on a packed tap bus as divided clocks. With the default parameters the chain has 14 stages, and stages 1, 2, 3 and 11 stay internal.

The clear input is active high. It forces every stage to zero at once, without waiting for a clock edge. It also drops an enable output, so that the clock source can be halted during standby. When the clear is removed, a two-flop synchroniser on the falling edge returns the chain to counting. A decode-qualify strobe follows the high phase of the oscillator clock while the chain is running. The count only moves on falling edges, so downstream logic can sample decoded tap combinations under this strobe without seeing an intermediate value.

Top module: `tapped_divider`

## Requirements
- R1: While `stop_clr` is high, every bit of `div_tap` is 0. This takes effect immediately on assertion, with no clock edge needed.
- R2: `osc_run_en` is 0 whenever `stop_clr` is high and 1 whenever it is low.
- R3: After `stop_clr` falls, the first and second falling edges of `osc_clk` do not advance the count. The third falling edge is the first one counted.
- R4: The taps change only on falling edges of `osc_clk`. They hold their value across rising edges and through the whole high phase.
- R5: Each counted falling edge adds one to the internal count C. Tap bit k equals bit (s-1) of C, where s is the k-th exposed stage in the order 4, 5, 6, 7, 8, 9, 10, 12, 13, 14. So `div_tap[0]` is stage 4, `div_tap[6]` is stage 10 and `div_tap[9]` is stage 14.
- R6: After a release, `div_tap[9]` (stage 14) is still 0 after 8191 counted edges and first goes to 1 after 8192 counted edges. At that point every other tap is 0.
- R7: After 16384 counted edges the count wraps from all ones to all zeros and keeps counting, with no stall.
- R8: `decode_ok` is 1 only while `osc_clk` is high, `stop_clr` is low and the chain is running, which is from the second falling edge after release onward. It is 0 throughout the low phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_clk | input | 1 | Oscillator clock; the count advances on its falling edge |
| stop_clr | input | 1 | Asynchronous active-high clear and standby request |
| osc_run_en | output | 1 | High when the oscillator may run, low during clear |
| decode_ok | output | 1 | Strobe marking the clock-high phase in which the taps are settled |
| div_tap | output | 10 | Exposed stage outputs, stage 4 in bit 0 up to stage 14 in bit 9 |

## Verification
The bench builds the block with its default parameters: 14 stages and the 4–10, 12–14 tap selection. At this size a full 16384-edge cycle, plus the first rise of stage 14, fits within about 17000 clocks. That is enough to watch the hidden stage 11 carry into stage 12 and to see the terminal wrap. A clear asserted partway through the count, followed by a second release, exercises the three-edge recovery twice. It also shows that stage outputs which were partly set are dropped at once rather than on the next edge.

// File: rtl/tapdiv_pkg.sv
// Package: helpers shared by the tapped divider modules.
// Assumes stage masks fit in 32 bits (chains of at most 32 stages).
package tapdiv_pkg;

    // Return the bit position of the k-th set bit of mask (k counts from 0).
    function automatic int nth_set_bit(logic [31:0] mask, int k);
        int seen;
        int pos;
        seen = 0;
        pos  = 0;
        for (int i = 0; i < 32; i++) begin
            if (mask[i]) begin
                if (seen == k) pos = i;
                seen++;
            end
        end
        return pos;
    endfunction

endpackage

// File: rtl/tapdiv_release_sync.sv
// Clear-release synchroniser: two flops clocked on the falling edge of the
// oscillator clock. Both are cleared asynchronously while clr is high, and
// run rises on the second falling edge after clr goes low.
// Assumes clr is held for at least one clock phase.
module tapdiv_release_sync (
    input  logic clk,
    input  logic clr,
    output logic run
);
    logic meta_q;
    logic run_q;

    // Shift a one through the two flops once clear is gone.
    always_ff @(negedge clk or posedge clr) begin
        if (clr) begin
            meta_q <= 1'b0;
            run_q  <= 1'b0;
        end else begin
            meta_q <= 1'b1;
            run_q  <= meta_q;
        end
    end

    assign run = run_q;

endmodule

// File: rtl/tapdiv_stage_chain.sv
// Stage chain: STAGES toggle flops advanced on the falling clock edge.
// Stage i toggles when run is high and every lower stage is one, which is
// the synchronous equivalent of a ripple chain. It wraps freely.
// Assumes clr is the asynchronous clear and run comes from the synchroniser.
module tapdiv_stage_chain #(
    parameter int STAGES = 14
) (
    input  logic              clk,
    input  logic              clr,
    input  logic              run,
    output logic [STAGES-1:0] cnt
);
    logic [STAGES:0] carry;

    assign carry[0] = run;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        // Carry into the next stage: this stage and all below are one.
        assign carry[i+1] = carry[i] & cnt[i];

        // Toggle this stage when the carry reaches it.
        always_ff @(negedge clk or posedge clr) begin
            if (clr) cnt[i] <= 1'b0;
            else if (carry[i]) cnt[i] <= ~cnt[i];
        end
    end

    // R3
    hold_when_idle_chk: assert property (@(negedge clk) disable iff (clr)
        !run |=> $stable(cnt));

    // R7
    count_step_chk: assert property (@(negedge clk) disable iff (clr)
        run |=> cnt == STAGES'($past(cnt) + 1'b1));

endmodule

// File: rtl/tapdiv_tap_pick.sv
// Tap selector: packs the stages flagged in TAP_SEL into a dense bus, with
// the lowest flagged stage in bit 0. Pure wiring.
// Assumes STAGES <= 32 and NUM_TAPS equals the number of ones in TAP_SEL.
module tapdiv_tap_pick #(
    parameter int                STAGES   = 14,
    parameter logic [STAGES-1:0] TAP_SEL  = 14'b11_1011_1111_1000,
    parameter int                NUM_TAPS = 10
) (
    input  logic [STAGES-1:0]   cnt,
    output logic [NUM_TAPS-1:0] taps
);
    for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
        localparam int SRC = tapdiv_pkg::nth_set_bit(32'(TAP_SEL), k);
        // Route the k-th selected stage to tap k.
        assign taps[k] = cnt[SRC];
    end

endmodule

// File: rtl/tapped_divider.sv
// Top of the tapped binary divider. It counts falling edges of osc_clk in a
// STAGES-long binary chain, exposes the stages selected by TAP_SEL, gates the
// oscillator enable with the clear and drives a decode-qualify strobe in the
// clock-high phase. Assumes osc_clk is free running while stop_clr is low.
module tapped_divider #(
    parameter int                STAGES   = 14,
    parameter logic [STAGES-1:0] TAP_SEL  = 14'b11_1011_1111_1000,
    localparam int               NUM_TAPS = $countones(TAP_SEL)
) (
    input  logic                osc_clk,
    input  logic                stop_clr,
    output logic                osc_run_en,
    output logic                decode_ok,
    output logic [NUM_TAPS-1:0] div_tap
);
    logic              run;
    logic [STAGES-1:0] cnt;

    tapdiv_release_sync u_sync (
        .clk (osc_clk),
        .clr (stop_clr),
        .run (run)
    );

    tapdiv_stage_chain #(.STAGES(STAGES)) u_chain (
        .clk (osc_clk),
        .clr (stop_clr),
        .run (run),
        .cnt (cnt)
    );

    tapdiv_tap_pick #(
        .STAGES   (STAGES),
        .TAP_SEL  (TAP_SEL),
        .NUM_TAPS (NUM_TAPS)
    ) u_pick (
        .cnt  (cnt),
        .taps (div_tap)
    );

    // Let the oscillator run only while no clear is requested.
    assign osc_run_en = ~stop_clr;

    // Qualify decodes in the high phase, where the count is settled.
    assign decode_ok = osc_clk & run & ~stop_clr;

    // R1
    taps_zero_in_clear_chk: assert property (@(posedge osc_clk)
        stop_clr |-> div_tap == '0);

    // R8
    strobe_low_phase_chk: assert property (@(posedge osc_clk) disable iff (stop_clr)
        !decode_ok);

endmodule

// File: tb/tapped_divider_tb_top.sv
module tapped_divider_tb_top;
    logic       osc_clk  = 1'b0;
    logic       stop_clr = 1'b0;
    logic       osc_run_en;
    logic       decode_ok;
    logic [9:0] div_tap;

    int n_cmp   = 0;
    int n_bad   = 0;
    int ref_cnt = 0;
    int rel     = 0;
    bit check_on = 1'b0;
    bit wrapped  = 1'b0;

    localparam int STG [10] = '{4, 5, 6, 7, 8, 9, 10, 12, 13, 14};

    always #10 osc_clk = ~osc_clk;

    tapped_divider dut_i (
        .osc_clk    (osc_clk),
        .stop_clr   (stop_clr),
        .osc_run_en (osc_run_en),
        .decode_ok  (decode_ok),
        .div_tap    (div_tap)
    );

    function automatic logic [9:0] exp_taps(int c);
        logic [9:0] e;
        for (int k = 0; k < 10; k++) e[k] = ((c >> (STG[k] - 1)) & 1) != 0;
        return e;
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Behavioural reference: edges since release and the counted value.
    always @(negedge osc_clk) begin
        if (stop_clr) begin
            rel = 0;
            ref_cnt = 0;
            wrapped = 1'b0;
        end else begin
            rel++;
            if (rel >= 3) begin
                ref_cnt++;
                if (ref_cnt == 16384) begin
                    ref_cnt = 0;
                    wrapped = 1'b1;
                end
            end
        end
    end

    // Compare in the middle of and late in the high phase.
    always @(posedge osc_clk) begin
        if (check_on) begin
            logic [9:0] e;
            logic [9:0] mid;
            #5;
            e = stop_clr ? 10'd0 : exp_taps(ref_cnt);
            chk(div_tap === e, "R3,R5", "taps", int'(div_tap), int'(e));
            chk(osc_run_en === !stop_clr, "R2", "osc_run_en", int'(osc_run_en), int'(!stop_clr));
            chk(decode_ok === (!stop_clr && rel >= 2), "R3,R8", "decode_ok high phase",
                int'(decode_ok), int'(!stop_clr && rel >= 2));
            if (!stop_clr && rel >= 3 && ref_cnt == 8191)
                chk(div_tap[9] === 1'b0, "R6", "stage14 before 8192", int'(div_tap[9]), 0);
            if (!stop_clr && ref_cnt == 8192)
                chk(div_tap === 10'h200, "R6", "stage14 first rise", int'(div_tap), 'h200);
            if (!stop_clr && wrapped && ref_cnt == 0) begin
                chk(div_tap === 10'h000, "R7", "wrap to zero", int'(div_tap), 0);
                wrapped = 1'b0;
            end
            mid = div_tap;
            #4;
            chk(div_tap === mid, "R4", "taps stable in high phase", int'(div_tap), int'(mid));
        end
    end

    always @(negedge osc_clk) begin
        if (check_on) begin
            #5;
            chk(decode_ok === 1'b0, "R8", "decode_ok low phase", int'(decode_ok), 0);
        end
    end

    task automatic apply_clear();
        @(posedge osc_clk);
        #2 stop_clr = 1'b1;
        #1;
        chk(div_tap === 10'd0, "R1", "taps cleared at once", int'(div_tap), 0);
        chk(osc_run_en === 1'b0, "R2", "enable dropped", int'(osc_run_en), 0);
    endtask

    task automatic release_clear();
        @(posedge osc_clk);
        #2 stop_clr = 1'b0;
    endtask

    initial begin
        #1 stop_clr = 1'b1;
        check_on = 1'b1;
        repeat (4) @(posedge osc_clk);
        release_clear();
        repeat (700) @(posedge osc_clk);
        apply_clear();
        repeat (5) @(posedge osc_clk);
        release_clear();
        repeat (16500) @(posedge osc_clk);
        #12;
        check_on = 1'b0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 20);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule